// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

This block is a synchronous true dual-port memory. A left port and a right port each own a chip select, a write strobe, an output enable, per-byte lane enables, an address and data buses. Both reach the same storage array. Either port can read or write any word on any cycle. Read data is registered and appears one clock after the access.

The two highest words of the array double as mailboxes. The top word, all address bits set, belongs to the left port. The word just below it belongs to the right port. When a port writes its own mailbox, the opposite port's active-low interrupt asserts on the next clock. When a port reads its own mailbox with its output enabled, its own interrupt releases on the next clock. The mailbox words keep the data written to them, so the message word can be fetched like any other word. Each interrupt flag stays set until it is cleared or reset. If a set and a clear of the same flag arrive together, the set is kept.

Top module: `dpr_mailbox_ram`

## Requirements
- R1: During and directly after reset, both interrupt outputs are high (inactive) and both read data buses are zero.
- R2: A write takes effect when cs=1, wr=1 and at least one byte enable is set. Only the lanes whose enable is set are updated (be[0] selects bits 7:0, be[1] selects bits 15:8). A later read returns the merged word.
- R3: With cs=0, or with every byte enable clear, a write strobe leaves the array unchanged.
- R4: A read takes effect when cs=1, wr=0, oe=1 and at least one byte enable is set. Its data is on the read bus one clock later, and disabled lanes read as zero. When no read takes effect, the read bus holds its previous value.
- R5: A left-port write to address all-ones drives r_irq_n low on the next clock. r_irq_n stays low while no clear happens.
- R6: A right-port read of address all-ones-minus-one, with oe=1, drives r_irq_n high on the next clock. A right-port access with oe=0, or a right-port read of any other address, leaves r_irq_n unchanged.
- R7: The same rules hold with the roles swapped. A right-port write to all-ones-minus-one drives l_irq_n low. A left-port read of all-ones with oe=1 drives it high.
- R8: When a set and a clear of the same interrupt flag happen in the same cycle, the flag ends up set.
- R9: The mailbox words store written data like any other word, and either port can read it back.
- R10: When both ports write the same address in one cycle, each byte lane that the left port enables takes the left data. Each lane that only the right port enables takes the right data.
- R11: When a port reads an address that the other port writes in the same cycle, it returns the word as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| l_cs | input | 1 | Left chip select |
| l_wr | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable, required for reads |
| l_be | input | LANES | Left byte lane enables |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 8*LANES | Left write data |
| l_rdata | output | 8*LANES | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs | input | 1 | Right chip select |
| r_wr | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_oe | input | 1 | Right output enable, required for reads |
| r_be | input | LANES | Right byte lane enables |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 8*LANES | Right write data |
| r_rdata | output | 8*LANES | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The hardest case to reach is a set and a clear of one flag landing in the same clock edge. This needs the setting port writing its mailbox while the receiving port reads its own, both in one cycle. The stimulus drives both ports from a single task call so that the two accesses share an edge. It first makes sure the flag is already set, and after the collision it confirms that the flag held and that a later clear on its own still releases it. The same two-port task produces the same-address write collision with partly overlapping lane enables, and a read that coincides with a write from the other port.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;

  // Mailbox word owned by a side: left owns the top word, right the one below.
  function automatic int unsigned mbox_addr(input side_e side, input int aw);
    int unsigned top;
    top = (32'd1 << aw) - 32'd1;
    return (side == SIDE_LEFT) ? top : top - 32'd1;
  endfunction

endpackage

// File: rtl/dpr_rst_sync.sv
module dpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/dpr_port_dec.sv
module dpr_port_dec #(
  parameter int            ADDR_W = 12,
  parameter int            LANES  = 2,
  parameter dpr_pkg::side_e SIDE  = dpr_pkg::SIDE_LEFT
) (
  input  logic              cs,
  input  logic              wr,
  input  logic              oe,
  input  logic [LANES-1:0]  be,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic              rd_en,
  output logic              set_peer,
  output logic              clr_self
);

  localparam logic [ADDR_W-1:0] MBOX = ADDR_W'(dpr_pkg::mbox_addr(SIDE, ADDR_W));

  logic selected;
  logic hit_mbox;

  always_comb begin
    selected = cs && (|be);
    hit_mbox = (addr == MBOX);
    wr_en    = selected && wr;
    rd_en    = selected && !wr && oe;
    set_peer = wr_en && hit_mbox;
    clr_self = rd_en && hit_mbox;
  end

endmodule

// File: rtl/dpr_irq_flag.sv
module dpr_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_n
);

  logic flag_q;
  logic flag_d;
  logic flag_ce;

  always_comb begin
    flag_ce = set_i || clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign irq_n = ~flag_q;

  // R8: set has priority over a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> !irq_n);

  // R6: a clear alone releases the interrupt
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> irq_n);

  // R5: with neither set nor clear the interrupt holds
  p_flag_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(irq_n));

endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
  parameter int ADDR_W = 12,
  parameter int LANES  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              l_wr_en,
  input  logic                              l_rd_en,
  input  logic [LANES-1:0]                  l_be,
  input  logic [ADDR_W-1:0]                 l_addr,
  input  logic [LANES*dpr_pkg::BYTE_W-1:0]  l_wdata,
  output logic [LANES*dpr_pkg::BYTE_W-1:0]  l_rdata,
  input  logic                              r_wr_en,
  input  logic                              r_rd_en,
  input  logic [LANES-1:0]                  r_be,
  input  logic [ADDR_W-1:0]                 r_addr,
  input  logic [LANES*dpr_pkg::BYTE_W-1:0]  r_wdata,
  output logic [LANES*dpr_pkg::BYTE_W-1:0]  r_rdata
);

  localparam int BW    = dpr_pkg::BYTE_W;
  localparam int DW    = LANES * BW;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] l_rd_d, r_rd_d;
  logic [DW-1:0] l_rd_q, r_rd_q;

  // Right lanes are written first so that left lanes overwrite on a collision.
  always_ff @(posedge clk) begin
    for (int b = 0; b < LANES; b++) begin
      if (r_wr_en && r_be[b]) mem[r_addr][b*BW +: BW] <= r_wdata[b*BW +: BW];
      if (l_wr_en && l_be[b]) mem[l_addr][b*BW +: BW] <= l_wdata[b*BW +: BW];
    end
  end

  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      l_rd_d[b*BW +: BW] = l_be[b] ? mem[l_addr][b*BW +: BW] : '0;
      r_rd_d[b*BW +: BW] = r_be[b] ? mem[r_addr][b*BW +: BW] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rd_q <= '0;
      r_rd_q <= '0;
    end else begin
      if (l_rd_en) l_rd_q <= l_rd_d;
      if (r_rd_en) r_rd_q <= r_rd_d;
    end
  end

  assign l_rdata = l_rd_q;
  assign r_rdata = r_rd_q;

  // R4: read bus holds when no read takes effect
  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_rd_en && !r_rd_en) |=> ($stable(l_rdata) && $stable(r_rdata)));

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
      // R4: a lane not enabled during a read comes back as zero
      p_lane_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rd_en && !l_be[g]) |=> (l_rdata[g*BW +: BW] == '0));
    end
  endgenerate

endmodule

// File: rtl/dpr_mailbox_ram.sv
module dpr_mailbox_ram #(
  parameter int ADDR_W = 12,
  parameter int LANES  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              l_cs,
  input  logic                              l_wr,
  input  logic                              l_oe,
  input  logic [LANES-1:0]                  l_be,
  input  logic [ADDR_W-1:0]                 l_addr,
  input  logic [LANES*dpr_pkg::BYTE_W-1:0]  l_wdata,
  output logic [LANES*dpr_pkg::BYTE_W-1:0]  l_rdata,
  output logic                              l_irq_n,
  input  logic                              r_cs,
  input  logic                              r_wr,
  input  logic                              r_oe,
  input  logic [LANES-1:0]                  r_be,
  input  logic [ADDR_W-1:0]                 r_addr,
  input  logic [LANES*dpr_pkg::BYTE_W-1:0]  r_wdata,
  output logic [LANES*dpr_pkg::BYTE_W-1:0]  r_rdata,
  output logic                              r_irq_n
);

  localparam int NPORT = 2;

  logic              rst_n_sync;
  logic              cs_a   [NPORT];
  logic              wr_a   [NPORT];
  logic              oe_a   [NPORT];
  logic [LANES-1:0]  be_a   [NPORT];
  logic [ADDR_W-1:0] addr_a [NPORT];
  logic              wr_en  [NPORT];
  logic              rd_en  [NPORT];
  logic              set_pr [NPORT];
  logic              clr_sf [NPORT];
  logic              irqn_a [NPORT];

  dpr_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  always_comb begin
    cs_a[0] = l_cs;   cs_a[1] = r_cs;
    wr_a[0] = l_wr;   wr_a[1] = r_wr;
    oe_a[0] = l_oe;   oe_a[1] = r_oe;
    be_a[0] = l_be;   be_a[1] = r_be;
    addr_a[0] = l_addr; addr_a[1] = r_addr;
  end

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_port
      localparam dpr_pkg::side_e SD = (g == 0) ? dpr_pkg::SIDE_LEFT : dpr_pkg::SIDE_RIGHT;

      dpr_port_dec #(.ADDR_W(ADDR_W), .LANES(LANES), .SIDE(SD)) u_dec (
        .cs      (cs_a[g]),
        .wr      (wr_a[g]),
        .oe      (oe_a[g]),
        .be      (be_a[g]),
        .addr    (addr_a[g]),
        .wr_en   (wr_en[g]),
        .rd_en   (rd_en[g]),
        .set_peer(set_pr[g]),
        .clr_self(clr_sf[g])
      );

      // Flag of port g is set by the opposite port and cleared by port g.
      dpr_irq_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n_sync),
        .set_i(set_pr[NPORT-1-g]),
        .clr_i(clr_sf[g]),
        .irq_n(irqn_a[g])
      );
    end
  endgenerate

  dpr_store #(.ADDR_W(ADDR_W), .LANES(LANES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .l_wr_en(wr_en[0]),
    .l_rd_en(rd_en[0]),
    .l_be   (l_be),
    .l_addr (l_addr),
    .l_wdata(l_wdata),
    .l_rdata(l_rdata),
    .r_wr_en(wr_en[1]),
    .r_rd_en(rd_en[1]),
    .r_be   (r_be),
    .r_addr (r_addr),
    .r_wdata(r_wdata),
    .r_rdata(r_rdata)
  );

  assign l_irq_n = irqn_a[0];
  assign r_irq_n = irqn_a[1];

endmodule

// File: tb/tb_dpr_mailbox_ram.sv
module tb_dpr_mailbox_ram;

  localparam logic [11:0] MB_L = 12'hFFF;
  localparam logic [11:0] MB_R = 12'hFFE;

  typedef struct {
    bit          cs;
    bit          wr;
    bit          oe;
    logic [1:0]  be;
    logic [11:0] a;
    logic [15:0] d;
  } op_t;

  typedef struct {
    int          due;
    bit          side;
    logic [15:0] exp;
    string       tag;
  } exp_t;

  logic clk, rst_n;
  logic l_cs, l_wr, l_oe, r_cs, r_wr, r_oe;
  logic [1:0] l_be, r_be;
  logic [11:0] l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  exp_t sb[$];
  exp_t item;

  dpr_mailbox_ram dut (
    .clk(clk), .rst_n(rst_n),
    .l_cs(l_cs), .l_wr(l_wr), .l_oe(l_oe), .l_be(l_be), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_cs(r_cs), .r_wr(r_wr), .r_oe(r_oe), .r_be(r_be), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Monitor: pops expected read results as they become due.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item = sb.pop_front();
      chk(item.side ? r_rdata : l_rdata, item.exp, item.tag);
    end
  end

  function automatic op_t nop();
    op_t o;
    o.cs = 0; o.wr = 0; o.oe = 0; o.be = 2'b00; o.a = '0; o.d = '0;
    return o;
  endfunction

  function automatic op_t wop(input logic [11:0] a, input logic [15:0] d, input logic [1:0] be);
    op_t o;
    o.cs = 1; o.wr = 1; o.oe = 0; o.be = be; o.a = a; o.d = d;
    return o;
  endfunction

  function automatic op_t rop(input logic [11:0] a, input logic [1:0] be);
    op_t o;
    o.cs = 1; o.wr = 0; o.oe = 1; o.be = be; o.a = a; o.d = '0;
    return o;
  endfunction

  // Driver: applies one cycle on both ports and queues the expected read data.
  task automatic cyc2(input op_t lo, input op_t ro,
                      input bit lchk, input logic [15:0] lexp,
                      input bit rchk, input logic [15:0] rexp, input string tag);
    exp_t e;
    @(negedge clk);
    l_cs = lo.cs; l_wr = lo.wr; l_oe = lo.oe; l_be = lo.be; l_addr = lo.a; l_wdata = lo.d;
    r_cs = ro.cs; r_wr = ro.wr; r_oe = ro.oe; r_be = ro.be; r_addr = ro.a; r_wdata = ro.d;
    if (lchk) begin e.due = cyc + 1; e.side = 0; e.exp = lexp; e.tag = tag; sb.push_back(e); end
    if (rchk) begin e.due = cyc + 1; e.side = 1; e.exp = rexp; e.tag = tag; sb.push_back(e); end
  endtask

  task automatic idle();
    cyc2(nop(), nop(), 0, '0, 0, '0, "idle");
  endtask

  task automatic lop(input op_t o, input bit c, input logic [15:0] x, input string tag);
    cyc2(o, nop(), c, x, 0, '0, tag);
  endtask

  task automatic rop_t(input op_t o, input bit c, input logic [15:0] x, input string tag);
    cyc2(nop(), o, 0, '0, c, x, tag);
  endtask

  initial begin
    op_t o;
    rst_n = 1'b0;
    l_cs = 0; l_wr = 0; l_oe = 0; l_be = 0; l_addr = 0; l_wdata = 0;
    r_cs = 0; r_wr = 0; r_oe = 0; r_be = 0; r_addr = 0; r_wdata = 0;
    repeat (3) @(negedge clk);
    chk({15'd0, l_irq_n}, 16'd1, "R1 l_irq_n in reset");
    chk({15'd0, r_irq_n}, 16'd1, "R1 r_irq_n in reset");
    chk(l_rdata, 16'h0000, "R1 l_rdata in reset");
    chk(r_rdata, 16'h0000, "R1 r_rdata in reset");
    rst_n = 1'b1;
    repeat (4) idle();
    chk({15'd0, l_irq_n}, 16'd1, "R1 l_irq_n after reset");
    chk(r_rdata, 16'h0000, "R1 r_rdata after reset");

    // R2: full and partial lane writes
    lop(wop(12'd5, 16'hA5C3, 2'b11), 0, '0, "R2");
    lop(rop(12'd5, 2'b11), 1, 16'hA5C3, "R2 full word");
    rop_t(wop(12'd5, 16'h1177, 2'b01), 0, '0, "R2");
    rop_t(rop(12'd5, 2'b11), 1, 16'hA577, "R2 low lane merge");
    lop(wop(12'd5, 16'h9900, 2'b10), 0, '0, "R2");
    lop(rop(12'd5, 2'b11), 1, 16'h9977, "R2 high lane merge");

    // R3: disabled writes
    lop(wop(12'd6, 16'h1234, 2'b11), 0, '0, "R3");
    o = wop(12'd6, 16'hFFFF, 2'b11); o.cs = 0;
    lop(o, 0, '0, "R3");
    rop_t(wop(12'd6, 16'hEEEE, 2'b00), 0, '0, "R3");
    lop(rop(12'd6, 2'b11), 1, 16'h1234, "R3 ignored writes");

    // R4: lane masking and hold
    lop(rop(12'd5, 2'b01), 1, 16'h0077, "R4 masked high lane");
    lop(rop(12'd5, 2'b10), 1, 16'h9900, "R4 masked low lane");
    o = rop(12'd6, 2'b11); o.oe = 0;
    lop(o, 1, 16'h9900, "R4 hold with oe low");
    o = rop(12'd6, 2'b11); o.cs = 0;
    lop(o, 1, 16'h9900, "R4 hold with cs low");
    idle();

    // R5: left sets right interrupt
    lop(wop(MB_L, 16'hBEEF, 2'b11), 0, '0, "R5");
    idle();
    chk({15'd0, r_irq_n}, 16'd0, "R5 r_irq_n set");
    chk({15'd0, l_irq_n}, 16'd1, "R5 l_irq_n untouched");
    repeat (3) idle();
    chk({15'd0, r_irq_n}, 16'd0, "R5 r_irq_n holds");

    // R9 and R6
    rop_t(rop(MB_L, 2'b11), 1, 16'hBEEF, "R9 right reads left mailbox");
    idle();
    chk({15'd0, r_irq_n}, 16'd0, "R6 other address does not clear");
    o = rop(MB_R, 2'b11); o.oe = 0;
    rop_t(o, 0, '0, "R6");
    idle();
    chk({15'd0, r_irq_n}, 16'd0, "R6 oe low does not clear");
    rop_t(rop(MB_R, 2'b11), 0, '0, "R6");
    idle();
    chk({15'd0, r_irq_n}, 16'd1, "R6 r_irq_n cleared");

    // R7: mirrored roles
    rop_t(wop(MB_R, 16'h4242, 2'b11), 0, '0, "R7");
    idle();
    chk({15'd0, l_irq_n}, 16'd0, "R7 l_irq_n set");
    chk({15'd0, r_irq_n}, 16'd1, "R7 r_irq_n untouched");
    lop(rop(MB_R, 2'b11), 1, 16'h4242, "R9 left reads right mailbox");
    idle();
    chk({15'd0, l_irq_n}, 16'd0, "R7 still set");
    lop(rop(MB_L, 2'b11), 1, 16'hBEEF, "R9 left reads own mailbox");
    idle();
    chk({15'd0, l_irq_n}, 16'd1, "R7 l_irq_n cleared");

    // R8: simultaneous set and clear
    lop(wop(MB_L, 16'hCAFE, 2'b11), 0, '0, "R8");
    idle();
    chk({15'd0, r_irq_n}, 16'd0, "R8 preset");
    cyc2(wop(MB_L, 16'hD00D, 2'b11), rop(MB_R, 2'b11), 0, '0, 1, 16'h4242, "R8 clear read data");
    idle();
    chk({15'd0, r_irq_n}, 16'd0, "R8 set wins");
    rop_t(rop(MB_R, 2'b11), 0, '0, "R8");
    idle();
    chk({15'd0, r_irq_n}, 16'd1, "R8 later clear");
    rop_t(rop(MB_L, 2'b11), 1, 16'hD00D, "R9 latest message");

    // R10: same-address write collisions
    cyc2(wop(12'd9, 16'hAA55, 2'b10), wop(12'd9, 16'h33CC, 2'b11), 0, '0, 0, '0, "R10");
    lop(rop(12'd9, 2'b11), 1, 16'hAACC, "R10 partial overlap");
    cyc2(wop(12'd9, 16'h1111, 2'b11), wop(12'd9, 16'h2222, 2'b11), 0, '0, 0, '0, "R10");
    rop_t(rop(12'd9, 2'b11), 1, 16'h1111, "R10 full overlap");

    // R11: read during other-port write
    lop(wop(12'd20, 16'h0F0F, 2'b11), 0, '0, "R11");
    cyc2(wop(12'd20, 16'hF0F0, 2'b11), rop(12'd20, 2'b11), 0, '0, 1, 16'h0F0F, "R11 old data");
    rop_t(rop(12'd20, 2'b11), 1, 16'hF0F0, "R11 new data");
    cyc2(rop(12'd20, 2'b11), wop(12'd20, 16'h5A5A, 2'b01), 1, 16'hF0F0, 0, '0, "R11 old data left");
    lop(rop(12'd20, 2'b11), 1, 16'hF05A, "R11 new data left");

    repeat (3) idle();
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", sb.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule